// File: doc/BRIEF.md
# Banked memory address mapper

This block turns every 16-bit CPU address of a home-computer clone into a physical location and a write permission. There are four possible targets: the external 64 MB DRAM (26-bit address), the 16 KB on-chip firmware RAM, the 16 KB on-chip video RAM (split into two 8 KB halves), and the built-in bootloader ROM. The mapping is purely combinational from the CPU address and a set of paging registers. Those registers are loaded by I/O port write cycles, and every port address is decoded in full.

Several mapping layers sit on top of classic 128K paging, and a fixed priority decides between them. In the lowest 16 KB the order is: the power-on bootloader overlay, then context (NMI) mode, then fastpage, then all-RAM special paging, then a DRAM ROM block. Fastpage maps any 16 KB block of a chosen 1 MB DRAM window. It can be relocated from the lowest quarter to the top quarter. The lower 8 KB of RAM banks 5 and 7 always come from video RAM.

Top module: `mem_page_map`

## Requirements
- R1: After reset, 0x0000–0x3FFF maps to the bootloader ROM (target 3, address = CPU address bits 13:0, not writable). Context mode is active and all other registers are zero. Target codes are 0 DRAM, 1 firmware RAM, 2 video RAM, 3 bootloader.
- R2: A write of any data to port 0x44DF removes the bootloader overlay. Only reset brings it back.
- R3: With no overlay, context mode maps 0x0000–0x3FFF to firmware RAM (address = CPU bits 13:0, writable), with priority over fastpage. `nmi_i` high at a clock edge sets context mode, and this wins over a port write in the same cycle. Port 0x14DF bit 0 writes the context flag.
- R4: In normal mode, 0x0000–0x3FFF reads DRAM block {1, P24DF[5:3], P1FFD[2], P7FFD[4]} of window 0 and is never writable. The DRAM address is {window[5:0], block[5:0], offset[13:0]}.
- R5: Port 0x54DF holds the fastpage block in bits 5:0, enable in bit 6 and write-protect in bit 7. With fastpage enabled and port 0x34DF bit 7 clear, 0x0000–0x3FFF (outside overlay and context mode) maps to DRAM {window, block, offset}. It is writable only when bit 7 is clear.
- R6: With port 0x34DF bit 7 set, fastpage moves to 0xC000–0xFFFF and is always writable. 0x0000–0x3FFF then falls back to its lower-priority mapping.
- R7: Port 0x64DF bits 5:0 select the DRAM window for fastpage accesses only. All other DRAM accesses use window 0.
- R8: An access to RAM bank 5 or 7 with offset bit 13 clear goes to video RAM at {bank bit 1, offset[12:0]} and is writable. The upper 8 KB goes to DRAM block = bank number.
- R9: Without special mode, 0x4000 maps RAM bank 5, 0x8000 maps bank 2, and 0xC000 maps the bank in port 0x7FFD bits 2:0. RAM bank n is DRAM block n of window 0, writable.
- R10: Port 0x1FFD bit 0 enables all-RAM mode. Bits 2:1 choose the banks for the four quarters: 0 = 0,1,2,3; 1 = 4,5,6,7; 2 = 4,5,6,3; 3 = 4,7,6,3. In that mode this table replaces the bank for 0x0000–0x3FFF below context mode and fastpage, and for the other quarters unless fastpage is relocated there.
- R11: A write to an address that differs from a paging port in any bit changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| io_wr_i | input | 1 | I/O write strobe, sampled at clock edge |
| io_addr_i | input | 16 | I/O port address |
| io_data_i | input | 8 | I/O write data |
| nmi_i | input | 1 | Enter context mode |
| cpu_addr_i | input | 16 | CPU memory address |
| tgt_o | output | 2 | Target: 0 DRAM, 1 firmware, 2 video, 3 bootloader |
| phys_addr_o | output | 26 | Physical address within the target |
| wr_en_o | output | 1 | Write permitted |

## Verification
Directed sequences cover the situations where two mapping layers compete: overlay against context mode, context mode against fastpage, and fastpage low against fastpage relocated. Each of these pairs yields a different target or write flag at the same address, so a wrong priority is visible. A near-miss port address shows whether the port decode is full. Random port writes with random data, random NMI pulses and random addresses then sweep every quarter under all four special-mode arrangements and many window and block values. Those results are compared against a bench-side reference, which separates video-RAM halves, DRAM window bits and write-protect handling.

// File: rtl/mpm_pkg.sv
package mpm_pkg;
  localparam int OFF_W = 14;
  localparam int BLK_W = 6;
  localparam int WIN_W = 6;
  localparam int PA_W  = WIN_W + BLK_W + OFF_W;
  localparam int SLOTS = 4;

  localparam logic [1:0] TGT_DRAM = 2'd0;
  localparam logic [1:0] TGT_FW   = 2'd1;
  localparam logic [1:0] TGT_VRAM = 2'd2;
  localparam logic [1:0] TGT_BOOT = 2'd3;

  localparam logic [15:0] PORT_BANK  = 16'h7FFD;
  localparam logic [15:0] PORT_PLUS  = 16'h1FFD;
  localparam logic [15:0] PORT_CTX   = 16'h14DF;
  localparam logic [15:0] PORT_EXT   = 16'h24DF;
  localparam logic [15:0] PORT_FPMD  = 16'h34DF;
  localparam logic [15:0] PORT_BOOT  = 16'h44DF;
  localparam logic [15:0] PORT_FP    = 16'h54DF;
  localparam logic [15:0] PORT_HIMB  = 16'h64DF;

  typedef struct packed {
    logic              boot;
    logic              ctx;
    logic [2:0]        bank_sel;
    logic              rom_lo;
    logic              plus_en;
    logic [1:0]        plus_cfg;
    logic              rom_hi;
    logic [2:0]        ext_rom;
    logic              reloc;
    logic              fp_wp;
    logic              fp_en;
    logic [BLK_W-1:0]  fp_blk;
    logic [WIN_W-1:0]  himb;
  } regs_t;

  function automatic logic [2:0] special_bank(input logic [1:0] cfg, input logic [1:0] slot);
    logic [11:0] row;
    case (cfg)
      2'd0:    row = {3'd3, 3'd2, 3'd1, 3'd0};
      2'd1:    row = {3'd7, 3'd6, 3'd5, 3'd4};
      2'd2:    row = {3'd3, 3'd6, 3'd5, 3'd4};
      default: row = {3'd3, 3'd6, 3'd7, 3'd4};
    endcase
    return row[slot*3 +: 3];
  endfunction

  function automatic logic [2:0] std_bank(input logic [1:0] slot, input logic [2:0] sel);
    case (slot)
      2'd1:    return 3'd5;
      2'd2:    return 3'd2;
      2'd3:    return sel;
      default: return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/mpm_regs.sv
module mpm_regs
  import mpm_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        io_wr_i,
  input  logic [15:0] io_addr_i,
  input  logic [7:0]  io_data_i,
  input  logic        nmi_i,
  output regs_t       regs_o
);
  regs_t q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q      <= '0;
      q.boot <= 1'b1;
      q.ctx  <= 1'b1;
    end else begin
      if (io_wr_i) begin
        case (io_addr_i)
          PORT_BANK: begin
            q.bank_sel <= io_data_i[2:0];
            q.rom_lo   <= io_data_i[4];
          end
          PORT_PLUS: begin
            q.plus_en  <= io_data_i[0];
            q.plus_cfg <= io_data_i[2:1];
            q.rom_hi   <= io_data_i[2];
          end
          PORT_CTX:  q.ctx     <= io_data_i[0];
          PORT_EXT:  q.ext_rom <= io_data_i[5:3];
          PORT_FPMD: q.reloc   <= io_data_i[7];
          PORT_BOOT: q.boot    <= 1'b0;
          PORT_FP: begin
            q.fp_blk <= io_data_i[BLK_W-1:0];
            q.fp_en  <= io_data_i[6];
            q.fp_wp  <= io_data_i[7];
          end
          PORT_HIMB: q.himb    <= io_data_i[WIN_W-1:0];
          default: ;
        endcase
      end
      if (nmi_i) q.ctx <= 1'b1;
    end
  end

  assign regs_o = q;
endmodule

// File: rtl/mpm_decode.sv
module mpm_decode
  import mpm_pkg::*;
(
  input  logic [15:0]     cpu_addr_i,
  input  regs_t           regs_i,
  output logic [1:0]      tgt_o,
  output logic [PA_W-1:0] phys_addr_o,
  output logic            wr_en_o
);
  logic [OFF_W-1:0] off;
  logic [1:0]       s_tgt [SLOTS];
  logic [PA_W-1:0]  s_pa  [SLOTS];
  logic             s_wr  [SLOTS];

  assign off = cpu_addr_i[OFF_W-1:0];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    localparam bit IS_LO = (g == 0);
    localparam bit IS_HI = (g == SLOTS - 1);
    localparam logic [1:0] SLOT = 2'(g);
    logic [2:0] ram_bank;
    logic       fp_hit;

    always_comb begin
      ram_bank = regs_i.plus_en ? special_bank(regs_i.plus_cfg, SLOT)
                                : std_bank(SLOT, regs_i.bank_sel);
      fp_hit   = regs_i.fp_en && ((IS_LO && !regs_i.reloc) || (IS_HI && regs_i.reloc));
      s_tgt[g] = TGT_DRAM;
      s_pa[g]  = {{WIN_W{1'b0}}, {(BLK_W-3){1'b0}}, ram_bank, off};
      s_wr[g]  = 1'b1;
      if (IS_LO && regs_i.boot) begin
        s_tgt[g] = TGT_BOOT;
        s_pa[g]  = PA_W'(off);
        s_wr[g]  = 1'b0;
      end else if (IS_LO && regs_i.ctx) begin
        s_tgt[g] = TGT_FW;
        s_pa[g]  = PA_W'(off);
      end else if (fp_hit) begin
        s_pa[g]  = {regs_i.himb, regs_i.fp_blk, off};
        s_wr[g]  = IS_HI || !regs_i.fp_wp;
      end else if (IS_LO && !regs_i.plus_en) begin
        s_pa[g]  = {{WIN_W{1'b0}}, 1'b1, regs_i.ext_rom, regs_i.rom_hi, regs_i.rom_lo, off};
        s_wr[g]  = 1'b0;
      end else if (ram_bank[2] && ram_bank[0] && !off[OFF_W-1]) begin
        // banks 5 and 7: lower 8 KB lives in video RAM
        s_tgt[g] = TGT_VRAM;
        s_pa[g]  = PA_W'({ram_bank[1], off[OFF_W-2:0]});
      end
    end
  end

  assign tgt_o       = s_tgt[cpu_addr_i[15:14]];
  assign phys_addr_o = s_pa[cpu_addr_i[15:14]];
  assign wr_en_o     = s_wr[cpu_addr_i[15:14]];
endmodule

// File: rtl/mem_page_map.sv
module mem_page_map
  import mpm_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        io_wr_i,
  input  logic [15:0] io_addr_i,
  input  logic [7:0]  io_data_i,
  input  logic        nmi_i,
  input  logic [15:0] cpu_addr_i,
  output logic [1:0]  tgt_o,
  output logic [25:0] phys_addr_o,
  output logic        wr_en_o
);
  regs_t regs_q;

  mpm_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .io_wr_i  (io_wr_i),
    .io_addr_i(io_addr_i),
    .io_data_i(io_data_i),
    .nmi_i    (nmi_i),
    .regs_o   (regs_q)
  );

  mpm_decode u_dec (
    .cpu_addr_i (cpu_addr_i),
    .regs_i     (regs_q),
    .tgt_o      (tgt_o),
    .phys_addr_o(phys_addr_o),
    .wr_en_o    (wr_en_o)
  );
endmodule

// File: rtl/mpm_checker.sv
module mpm_checker
  import mpm_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        nmi_i,
  input logic [15:0] cpu_addr_i,
  input logic [1:0]  tgt_o,
  input logic [25:0] phys_addr_o,
  input logic        wr_en_o,
  input regs_t       regs_i
);
  p_boot_ro_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tgt_o == TGT_BOOT) |-> (!wr_en_o && cpu_addr_i[15:14] == 2'b00));

  p_boot_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !regs_i.boot |=> !regs_i.boot);

  p_nmi_ctx_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_i |=> regs_i.ctx);

  p_rom_ro_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tgt_o == TGT_DRAM && cpu_addr_i[15:14] == 2'b00 && !regs_i.fp_en && !regs_i.plus_en)
      |-> !wr_en_o);

  p_reloc_wr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (regs_i.fp_en && regs_i.reloc && cpu_addr_i[15:14] == 2'b11) |-> (wr_en_o && tgt_o == TGT_DRAM));

  p_window_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tgt_o == TGT_DRAM && phys_addr_o[25:20] != 6'd0) |-> regs_i.fp_en);

  p_vram_half_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tgt_o == TGT_VRAM) |-> (!cpu_addr_i[13] && wr_en_o && phys_addr_o[25:14] == 12'd0));
endmodule

bind mem_page_map mpm_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .nmi_i      (nmi_i),
  .cpu_addr_i (cpu_addr_i),
  .tgt_o      (tgt_o),
  .phys_addr_o(phys_addr_o),
  .wr_en_o    (wr_en_o),
  .regs_i     (regs_q)
);

// File: tb/mem_page_map_test.sv
module mem_page_map_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        io_wr = 0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_data = '0;
  logic        nmi = 0;
  logic [15:0] cpu_addr = '0;
  logic [1:0]  tgt;
  logic [25:0] pa;
  logic        wr_en;

  int checks = 0;
  int errors = 0;

  // bench shadow of the paging state
  logic       m_boot, m_ctx, m_rom_lo, m_plus_en, m_rom_hi, m_reloc, m_fp_wp, m_fp_en;
  logic [2:0] m_bank, m_ext;
  logic [1:0] m_cfg;
  logic [5:0] m_fp_blk, m_himb;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_page_map uut (
    .clk_i(clk), .rst_ni(rst_n), .io_wr_i(io_wr), .io_addr_i(io_addr),
    .io_data_i(io_data), .nmi_i(nmi), .cpu_addr_i(cpu_addr),
    .tgt_o(tgt), .phys_addr_o(pa), .wr_en_o(wr_en)
  );

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog: act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic model_reset();
    m_boot = 1; m_ctx = 1; m_rom_lo = 0; m_plus_en = 0; m_rom_hi = 0; m_reloc = 0;
    m_fp_wp = 0; m_fp_en = 0; m_bank = 0; m_ext = 0; m_cfg = 0; m_fp_blk = 0; m_himb = 0;
  endtask

  function automatic logic [2:0] plus_bank(input logic [1:0] cfg, input int q);
    int t [4][4] = '{'{0,1,2,3}, '{4,5,6,7}, '{4,5,6,3}, '{4,7,6,3}};
    return 3'(t[cfg][q]);
  endfunction

  // returns {tgt, addr, wr}
  function automatic logic [28:0] expect_map(input logic [15:0] a);
    int q = int'(a[15:14]);
    logic [13:0] o = a[13:0];
    logic [2:0] b;
    if (q == 0 && m_boot) return {2'd3, 26'(o), 1'b0};
    if (q == 0 && m_ctx)  return {2'd1, 26'(o), 1'b1};
    if (m_fp_en && ((q == 0 && !m_reloc) || (q == 3 && m_reloc)))
      return {2'd0, m_himb, m_fp_blk, o, (q == 3) ? 1'b1 : !m_fp_wp};
    if (q == 0 && !m_plus_en)
      return {2'd0, 6'd0, 1'b1, m_ext, m_rom_hi, m_rom_lo, o, 1'b0};
    if (m_plus_en) b = plus_bank(m_cfg, q);
    else b = (q == 1) ? 3'd5 : (q == 2) ? 3'd2 : m_bank;
    if ((b == 5 || b == 7) && !o[13]) return {2'd2, 26'({b == 7, o[12:0]}), 1'b1};
    return {2'd0, 6'd0, 3'd0, b, o, 1'b1};
  endfunction

  function automatic string req_of(input logic [15:0] a);
    int q = int'(a[15:14]);
    if (q == 0 && m_boot) return "R1";
    if (q == 0 && m_ctx) return "R3";
    if (m_fp_en && q == 0 && !m_reloc) return "R5";
    if (m_fp_en && q == 3 && m_reloc) return "R6";
    if (m_plus_en) return "R10";
    if (q == 0) return "R4";
    if ((q == 1 || (q == 3 && (m_bank == 5 || m_bank == 7))) && !a[13]) return "R8";
    return "R9";
  endfunction

  task automatic check_addr(input logic [15:0] a, input string tag);
    logic [28:0] e;
    @(negedge clk);
    cpu_addr = a;
    #1;
    e = expect_map(a);
    checks++;
    if ({tgt, pa, wr_en} !== e) begin
      errors++;
      $display("FAIL %s addr=%h act tgt=%0d pa=%h wr=%0d exp tgt=%0d pa=%h wr=%0d",
               tag, a, tgt, pa, wr_en, e[28:27], e[26:1], e[0]);
    end
  endtask

  task automatic io_write(input logic [15:0] p, input logic [7:0] d, input logic do_nmi);
    @(negedge clk);
    io_wr = 1; io_addr = p; io_data = d; nmi = do_nmi;
    @(negedge clk);
    io_wr = 0; nmi = 0;
    case (p)
      16'h7FFD: begin m_bank = d[2:0]; m_rom_lo = d[4]; end
      16'h1FFD: begin m_plus_en = d[0]; m_cfg = d[2:1]; m_rom_hi = d[2]; end
      16'h14DF: m_ctx = d[0];
      16'h24DF: m_ext = d[5:3];
      16'h34DF: m_reloc = d[7];
      16'h44DF: m_boot = 0;
      16'h54DF: begin m_fp_blk = d[5:0]; m_fp_en = d[6]; m_fp_wp = d[7]; end
      16'h64DF: m_himb = d[5:0];
      default: ;
    endcase
    if (do_nmi) m_ctx = 1;
  endtask

  initial begin
    logic [15:0] ports [10] = '{16'h7FFD, 16'h1FFD, 16'h14DF, 16'h24DF, 16'h34DF,
                                16'h54DF, 16'h64DF, 16'h7FFE, 16'h54DE, 16'h44DE};
    void'($urandom(32'h5A17));
    model_reset();
    #(CLK_PERIOD * 3);
    rst_n = 1;
    // R1 reset state
    check_addr(16'h0123, "R1");
    check_addr(16'h8000, "R9");
    // R11 near-miss ports
    io_write(16'h7FFC, 8'h03, 0);
    io_write(16'h44DE, 8'h00, 0);
    check_addr(16'hC010, "R11");
    check_addr(16'h0010, "R11");
    // R2 overlay removal, R3 context
    io_write(16'h44DF, 8'h00, 0);
    check_addr(16'h3FFF, "R2");
    io_write(16'h54DF, 8'h4A, 0);
    check_addr(16'h0200, "R3");
    io_write(16'h14DF, 8'h00, 0);
    check_addr(16'h0200, "R5");
    io_write(16'h54DF, 8'hCA, 0);
    check_addr(16'h0200, "R5");
    io_write(16'h64DF, 8'h2B, 0);
    check_addr(16'h1234, "R7");
    check_addr(16'h8004, "R7");
    // R6 relocation: write protect ignored
    io_write(16'h34DF, 8'h80, 0);
    check_addr(16'hC777, "R6");
    io_write(16'h24DF, 8'h28, 0);
    check_addr(16'h0001, "R4");
    // R3 NMI beats port clear
    io_write(16'h14DF, 8'h00, 1);
    check_addr(16'h0040, "R3");
    io_write(16'h14DF, 8'h00, 0);
    io_write(16'h34DF, 8'h00, 0);
    io_write(16'h54DF, 8'h00, 0);
    // R8 video split
    io_write(16'h7FFD, 8'h17, 0);
    check_addr(16'hC100, "R8");
    check_addr(16'hE100, "R8");
    check_addr(16'h5FFF, "R8");
    check_addr(16'h6000, "R8");
    check_addr(16'h0100, "R4");
    // R10 all four arrangements
    for (int c = 0; c < 4; c++) begin
      io_write(16'h1FFD, 8'(c * 2 + 1), 0);
      for (int q = 0; q < 4; q++) check_addr(16'(q * 16384 + 'h100), "R10");
    end
    io_write(16'h1FFD, 8'h00, 0);
    // random sweep
    for (int i = 0; i < 600; i++) begin
      io_write(ports[$urandom_range(0, 9)], 8'($urandom), ($urandom_range(0, 15) == 0));
      for (int k = 0; k < 3; k++) begin
        logic [15:0] a = 16'($urandom);
        check_addr(a, req_of(a));
      end
    end
    // R2 overlay stays gone, returns on reset
    io_write(16'h14DF, 8'h00, 0);
    check_addr(16'h0002, "R2");
    rst_n = 0;
    model_reset();
    #(CLK_PERIOD);
    rst_n = 1;
    check_addr(16'h0002, "R1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule